// File: doc/BRIEF.md
# BCD Preloaded Down-Counter Frequency Divider

This block divides its clock by a ratio set from two BCD switch digits, a coarse digit and a fine digit. The digits are copied into a two-digit BCD down-counter. The counter runs down to a terminal value. The terminal decode works in two levels: the upper digit gives a reset-enable, and the lower digit can complete the match only while that enable is active.

When the terminal value is reached, the block does not reload in one cycle. It runs a fixed reload sequence:

1. An initialize cycle forces every counter bit to one.
2. One count is inhibited.
3. A preload cycle copies the switch settings into the counter.
4. A settle cycle follows.

Counting then resumes. An odd fine digit holds off the first down-count step by one extra clock. So the division ratio for setting N = 10·coarse + fine is N + 5 + (fine & 1).

The block gives three outputs:
- A divided count pulse. Its width follows from the setting.
- A one-cycle terminal strobe.
- A one-cycle preload strobe.

The preload strobe can drive the load of downstream dividers that share the same switches.

Top module: `bcd_preload_divider`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block enters its settle step and loads the clamped switch digits. During that step `preload_strobe` and `term_strobe` are 0 and `div_pulse` is 1.
- R2: With valid digits (0..9), the number of clock cycles from one `preload_strobe` to the next is 10·coarse + fine + 5 + (fine bit 0).
- R3: `term_strobe` is high for exactly one cycle per division period, when both counter digits equal the terminal value (default 00). `preload_strobe` is asserted exactly three cycles after it.
- R4: `preload_strobe` is a single-cycle pulse and occurs exactly once per division period.
- R5: When bit 0 of the loaded fine digit is 1, one extra delay cycle comes between the settle step and the first down-count. The terminal strobe and the period are therefore one cycle later than for the same setting with bit 0 cleared.
- R6: `div_pulse` is high in the preload cycle, in the settle and delay cycles, and in every counting cycle whose upper digit is above 0. Its width per period is 2 + (fine bit 0) + max(0, N − 9).
- R7: A switch digit above 9 is loaded as 9.
- R8: The switch inputs are sampled only at the clock edge that ends the preload cycle. A change made after that edge has no effect on the current period and takes effect in the next one.
- R9: After `rst_n` is released, the first `preload_strobe` comes N + 4 + (fine bit 0) cycles later, counting the first cycle with `rst_n` high as cycle 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sw_coarse | input | 4 | Coarse BCD setting digit (weights 8,4,2,1) |
| sw_fine | input | 4 | Fine BCD setting digit (weights 8,4,2,1); bit 0 selects the start delay |
| div_pulse | output | 1 | Divided count pulse |
| term_strobe | output | 1 | One-cycle terminal-count strobe |
| preload_strobe | output | 1 | One-cycle preload strobe |

## Verification
The bench drives the shortest setting, 00. Here the terminal is decoded in the first counting cycle, so an off-by-one in the reload sequence shows up at once as a period other than 5.

It sweeps all hundred valid settings, paired by odd and even fine digit. This exposes a start delay that is missing, inverted or two cycles long, and a borrow from the fine digit into the coarse digit that fails at 10→09, which would stretch or shorten the pulse width.

Out-of-range digits must clamp to 9 rather than count from 15. A switch change in the settle cycle must not shorten the running period, which would happen if the inputs were sampled anywhere but at the preload.

// File: rtl/bcd_div_pkg.sv
// Shared types and helpers for the BCD preloaded divider.
// Assumes 4-bit BCD digits with weights 8,4,2,1.
package bcd_div_pkg;

    localparam int DIG_W = 4;

    // Steps of the reload sequence; SQ_COUNT is the normal down-count step.
    typedef enum logic [2:0] {
        SQ_COUNT   = 3'd0,
        SQ_INIT    = 3'd1,
        SQ_INHIBIT = 3'd2,
        SQ_LOAD    = 3'd3,
        SQ_SETTLE  = 3'd4,
        SQ_DELAY   = 3'd5
    } seq_e;

    // Limit a switch digit to the BCD range 0..9.
    function automatic logic [DIG_W-1:0] clamp_digit(input logic [DIG_W-1:0] d);
        return (d > 4'd9) ? 4'd9 : d;
    endfunction

endpackage

// File: rtl/bcd_digit.sv
// One BCD down-counting digit.
// Priority: force-all-ones, load (clamped), decrement with wrap 0 -> 9.
// Assumes the caller supplies the borrow-qualified decrement enable.
module bcd_digit
    import bcd_div_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_all,
    input  logic             load,
    input  logic [DIG_W-1:0] load_val,
    input  logic             dec,
    output logic [DIG_W-1:0] q
);

    // Digit register: reset and load take the clamped switch value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= clamp_digit(load_val);
        end else if (set_all) begin
            q <= '1;
        end else if (load) begin
            q <= clamp_digit(load_val);
        end else if (dec) begin
            q <= (q == '0) ? 4'd9 : q - 4'd1;
        end
    end

    // R7
    digit_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (q <= 4'd9));

endmodule

// File: rtl/bcd_down_reg.sv
// Multi-digit BCD down-counter made of bcd_digit stages.
// A digit decrements only when every lower digit reads zero (borrow chain).
// Assumes digit 0 is the least significant (fine) digit.
module bcd_down_reg
    import bcd_div_pkg::*;
#(
    parameter int N_DIG = 2
)(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   set_all,
    input  logic                   load,
    input  logic                   dec,
    input  logic [N_DIG*DIG_W-1:0] set_vec,
    output logic [N_DIG*DIG_W-1:0] cnt_vec
);

    logic [N_DIG-1:0] dec_chain;

    genvar i;
    generate
        for (i = 0; i < N_DIG; i++) begin : g_dig
            // Borrow chain: a digit steps only when all lower digits are zero.
            if (i == 0) begin : g_lsd
                assign dec_chain[i] = dec;
            end else begin : g_upper
                assign dec_chain[i] = dec_chain[i-1] &&
                                      (cnt_vec[(i-1)*DIG_W +: DIG_W] == '0);
            end

            bcd_digit u_digit (
                .clk      (clk),
                .rst_n    (rst_n),
                .set_all  (set_all),
                .load     (load),
                .load_val (set_vec[i*DIG_W +: DIG_W]),
                .dec      (dec_chain[i]),
                .q        (cnt_vec[i*DIG_W +: DIG_W])
            );
        end
    endgenerate

endmodule

// File: rtl/term_decode.sv
// Two-level terminal decode.
// The upper digit match gives a reset-enable.
// The lower digit match completes the terminal only while that enable is set,
// and only in the counting step.
module term_decode
    import bcd_div_pkg::*;
#(
    parameter int TERM_HI = 0,
    parameter int TERM_LO = 0
)(
    input  logic             counting,
    input  logic [DIG_W-1:0] hi,
    input  logic [DIG_W-1:0] lo,
    output logic             term
);

    localparam logic [DIG_W-1:0] TERM_HI_D = DIG_W'(TERM_HI);
    localparam logic [DIG_W-1:0] TERM_LO_D = DIG_W'(TERM_LO);

    logic rst_en;

    // Upper-section decode: arms the lower-section match.
    always_comb rst_en = (hi == TERM_HI_D);

    // Lower-section decode, gated by the upper enable.
    always_comb term = counting && rst_en && (lo == TERM_LO_D);

endmodule

// File: rtl/div_sequencer.sv
// Reload sequencer for the divider.
// Order after a terminal match: initialize, inhibited count, preload, settle,
// then an optional delay step when the loaded fine digit is odd, then count.
// Assumes term_i is only raised in SQ_COUNT.
module div_sequencer
    import bcd_div_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic term_i,
    input  logic lsb_i,
    output seq_e state_o
);

    seq_e nxt;

    // Next-step selection.
    always_comb begin
        nxt = state_o;
        unique case (state_o)
            SQ_COUNT:   nxt = term_i ? SQ_INIT : SQ_COUNT;
            SQ_INIT:    nxt = SQ_INHIBIT;
            SQ_INHIBIT: nxt = SQ_LOAD;
            SQ_LOAD:    nxt = SQ_SETTLE;
            SQ_SETTLE:  nxt = lsb_i ? SQ_DELAY : SQ_COUNT;
            SQ_DELAY:   nxt = SQ_COUNT;
            default:    nxt = SQ_SETTLE;
        endcase
    end

    // Step register; reset parks the sequencer in the settle step.
    always_ff @(posedge clk) begin
        if (!rst_n) state_o <= SQ_SETTLE;
        else        state_o <= nxt;
    end

    // R3
    term_to_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == SQ_LOAD) |-> $past(term_i, 3));

    // R4
    load_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == SQ_LOAD) |=> (state_o != SQ_LOAD));

    // R5
    odd_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == SQ_SETTLE && lsb_i) |=> (state_o == SQ_DELAY));

endmodule

// File: rtl/bcd_preload_divider.sv
// Top of the BCD preloaded down-counter divider.
// Digit 1 holds the coarse setting and digit 0 the fine setting.
// Assumes one clock domain and a synchronous active-low reset.
module bcd_preload_divider
    import bcd_div_pkg::*;
#(
    parameter int TERM_HI  = 0,
    parameter int TERM_LO  = 0,
    parameter int PULSE_HI = 0
)(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] sw_coarse,
    input  logic [3:0] sw_fine,
    output logic       div_pulse,
    output logic       term_strobe,
    output logic       preload_strobe
);

    localparam int N_DIG = 2;
    localparam int VEC_W = N_DIG * DIG_W;
    localparam logic [DIG_W-1:0] PULSE_HI_D = DIG_W'(PULSE_HI);

    logic [VEC_W-1:0] set_vec;
    logic [VEC_W-1:0] cnt_vec;
    logic [DIG_W-1:0] hi_dig;
    logic [DIG_W-1:0] lo_dig;
    seq_e             st;
    logic             term;
    logic             counting;
    logic             do_load;
    logic             do_dec;

    // Switch digits packed most significant first.
    always_comb set_vec = {sw_coarse, sw_fine};
    always_comb hi_dig  = cnt_vec[VEC_W-1 -: DIG_W];
    always_comb lo_dig  = cnt_vec[DIG_W-1:0];

    // Step decode for the counter controls.
    always_comb begin
        counting = (st == SQ_COUNT);
        do_load  = (st == SQ_LOAD);
        do_dec   = counting && !term;
    end

    bcd_down_reg #(.N_DIG(N_DIG)) u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_all (term),
        .load    (do_load),
        .dec     (do_dec),
        .set_vec (set_vec),
        .cnt_vec (cnt_vec)
    );

    term_decode #(.TERM_HI(TERM_HI), .TERM_LO(TERM_LO)) u_dec (
        .counting (counting),
        .hi       (hi_dig),
        .lo       (lo_dig),
        .term     (term)
    );

    div_sequencer u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .term_i  (term),
        .lsb_i   (lo_dig[0]),
        .state_o (st)
    );

    // Output strobes and the divided pulse.
    always_comb begin
        term_strobe    = term;
        preload_strobe = do_load;
        div_pulse      = (st == SQ_LOAD) || (st == SQ_SETTLE) || (st == SQ_DELAY) ||
                         (counting && (hi_dig > PULSE_HI_D));
    end

    // R6
    pulse_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(div_pulse) |-> preload_strobe);

    // R3
    term_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        term_strobe |=> !term_strobe);

endmodule

// File: tb/bcd_preload_divider_test.sv
`timescale 1ns/1ps
module bcd_preload_divider_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] sw_c = '0;
    logic [3:0] sw_f = '0;
    logic       pulse, term, pre;
    int         total = 0;
    int         bad = 0;
    int         cyc = 0;
    bit         done = 1'b0;

    always #4 clk = ~clk;

    bcd_preload_divider uut (
        .clk(clk), .rst_n(rst_n), .sw_coarse(sw_c), .sw_fine(sw_f),
        .div_pulse(pulse), .term_strobe(term), .preload_strobe(pre)
    );

    // Vectors: coarse, fine, first preload after reset, period, pulse width.
    localparam int NV = 12;
    localparam int VEC [NV][5] = '{
        '{ 0,  0,   4,   5,  2}, '{ 0,  1,   6,   7,  3},
        '{ 0,  5,  10,  11,  3}, '{ 1,  0,  14,  15,  3},
        '{ 2,  3,  28,  29, 17}, '{ 3,  4,  38,  39, 27},
        '{ 4,  8,  52,  53, 41}, '{ 5,  5,  60,  61, 49},
        '{ 7,  2,  76,  77, 65}, '{ 9,  9, 104, 105, 93},
        '{12, 15, 104, 105, 93}, '{10,  3,  98,  99, 87}
    };

    task automatic check(input bit ok, input string what, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    // Hold reset, check the reset-state outputs, release at a falling edge.
    task automatic do_reset(input int c, input int f);
        @(negedge clk);
        sw_c = 4'(c); sw_f = 4'(f); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check(pre == 1'b0, "R1 preload in reset", int'(pre), 0);
        check(term == 1'b0, "R1 terminal in reset", int'(term), 0);
        check(pulse == 1'b1, "R1 pulse in reset", int'(pulse), 1);
        rst_n = 1'b1;
    endtask

    // Count cycles from reset release to the first preload.
    task automatic wait_preload(output int k);
        k = -1;
        for (int i = 0; i < 400; i++) begin
            if (pre) begin k = i; break; end
            @(negedge clk);
        end
    endtask

    // Measure one period starting at a preload cycle; optionally change switches at cycle 1.
    task automatic measure(input bit swap, input int nc, input int nf,
                           output int per, output int w, output int tc, output int tp,
                           output bit rise_ok);
        int k = 0;
        w = 0; tc = 0; tp = -1; rise_ok = pulse;
        while (k < 400) begin
            if (pulse) w++;
            if (term) begin tc++; tp = k; end
            @(negedge clk);
            k++;
            if (swap && k == 1) begin sw_c = 4'(nc); sw_f = 4'(nf); end
            if (pre) break;
        end
        per = k;
    endtask

    task automatic run_setting(input int c, input int f, input int efirst,
                               input int eper, input int ew);
        int first, per, w, tc, tp;
        bit rise_ok;
        do_reset(c, f);
        wait_preload(first);
        check(first == efirst, $sformatf("R9 first preload c=%0d f=%0d", c, f), first, efirst);
        measure(1'b0, 0, 0, per, w, tc, tp, rise_ok);
        check(per == eper, $sformatf("R2 R5 R7 period c=%0d f=%0d", c, f), per, eper);
        check(w == ew, $sformatf("R6 pulse width c=%0d f=%0d", c, f), w, ew);
        check(rise_ok, $sformatf("R6 pulse high at preload c=%0d f=%0d", c, f), int'(rise_ok), 1);
        check(tc == 1 && tp == per - 3, $sformatf("R3 terminal position c=%0d f=%0d", c, f),
              tp, per - 3);
        @(negedge clk);
        check(pre == 1'b0, $sformatf("R4 preload single cycle c=%0d f=%0d", c, f), int'(pre), 0);
    endtask

    function automatic int exp_per(input int c, input int f);
        return 10*c + f + 5 + (f % 2);
    endfunction

    function automatic int exp_w(input int c, input int f);
        int n = 10*c + f;
        return 2 + (f % 2) + ((n > 9) ? n - 9 : 0);
    endfunction

    task automatic finish_run();
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // Watchdog: a hung run is counted as a failure.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 150000);
            finish_run();
        end
    end

    initial begin
        int per, w, tc, tp;
        bit rise_ok;

        // Table of vectors, including clamped digits (R7).
        for (int v = 0; v < NV; v++)
            run_setting(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4]);

        // Full sweep of valid settings; odd fine digits add one cycle (R5).
        for (int c = 0; c < 10; c++)
            for (int f = 0; f < 10; f++)
                run_setting(c, f, 4 + (f % 2) + 10*c + f, exp_per(c, f), exp_w(c, f));

        // R8: switch change during the settle cycle keeps the running period.
        do_reset(2, 0);
        wait_preload(per);
        measure(1'b1, 0, 0, per, w, tc, tp, rise_ok);
        check(per == 25, "R8 period after mid-cycle change", per, 25);
        measure(1'b0, 0, 0, per, w, tc, tp, rise_ok);
        check(per == 5, "R8 new setting next period", per, 5);

        // R8: change to an odd setting; the delay applies only from the next load.
        measure(1'b1, 0, 3, per, w, tc, tp, rise_ok);
        check(per == 5, "R8 R5 old even period kept", per, 5);
        measure(1'b0, 0, 0, per, w, tc, tp, rise_ok);
        check(per == 9, "R8 R5 odd setting next period", per, 9);

        // R9: reset in mid-count restarts the sequence.
        do_reset(9, 9);
        repeat (30) @(negedge clk);
        do_reset(0, 2);
        wait_preload(per);
        check(per == 6, "R9 restart after mid-count reset", per, 6);

        finish_run();
    end

endmodule